// File: doc/BRIEF.md
# Byte-Wide Configurable Binary BCH Encoder

This block protects a flash page with a systematic binary BCH code while exchanging data one byte per clock. A one-cycle start strobe captures two selection codes: one picks how many bit errors the code can correct and the other picks the message length in bytes. The message bytes then enter over a valid/ready handshake. Each accepted byte is copied to the output and also divided, eight bits at a time, by the selected generator polynomial. When the last message byte has been taken, the input stalls and the remainder leaves as parity, one byte per clock, with its most significant byte first.

The generators come from minimal polynomials over GF(2^13), and the package computes them at elaboration. Each generator is then multiplied by x^p, where p is the smallest value that makes its degree a whole number of bytes. Seen from outside, the block therefore behaves like a byte-symbol encoder: message bytes come out first and a fixed number of parity bytes follow them.

Top module: `bch_byte_encoder`

## Requirements
- R1: After reset, and until a start strobe arrives, in_ready, out_valid, out_parity_first and out_last are all low.
- R2: A start strobe is acted on only while the block is idle. At that edge t_sel and k_sel are captured and held for the whole codeword; a strobe while busy has no effect. t_sel codes 0 to 5 select t = 7, 8, 14, 15, 17, 18, and codes 6 and 7 select t = 18. k_sel codes 0, 1, 2 select K = 514, 515, 516 bytes, and code 3 selects 516.
- R3: Every byte accepted (in_valid and in_ready high at a clock edge) appears on out_data with out_valid high in the following cycle, in order and unchanged, with both flags low.
- R4: After the K message bytes exactly R parity bytes follow, where R = 12, 13, 23, 25, 28, 30 for t = 7, 8, 14, 15, 17, 18.
- R5: Take the output stream, MSB of the first byte first, as the polynomial c(x), with the first bit as the highest power. Then c(α^i) = 0 for i = 1..2t, where α is a root of x^13+x^4+x^3+x+1. In addition, the final 8R-13t bits of the codeword are zero.
- R6: out_parity_first is high only while the first parity byte is shown, and out_last is high only while the final parity byte is shown.
- R7: in_ready is high from the cycle after an accepted start until K bytes have been accepted. It is low while parity is emitted, and the parity bytes leave on consecutive cycles with no gap.
- R8: in_valid asserted while in_ready is low (idle or parity phase) has no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a codeword; sampled while idle |
| t_sel | input | 3 | Correction strength code |
| k_sel | input | 2 | Message length code |
| in_valid | input | 1 | Message byte present |
| in_data | input | 8 | Message byte |
| in_ready | output | 1 | Block accepts a message byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Codeword byte |
| out_parity_first | output | 1 | Marks the first parity byte |
| out_last | output | 1 | Marks the final codeword byte |

## Verification
On every cycle the assertions check the local timing rules. These are the one-cycle pass-through of accepted bytes, the validity and exclusivity of the two flags, in_ready staying low and the output staying gapless during parity, and a parity run length between 12 and 30 bytes. Only the bench scenarios can show that the parity bytes are correct: the bench evaluates the whole codeword at every root α^i and checks the zero padding bits for all eighteen t and K pairings. The bench scenarios also cover the decoding of out-of-range selection codes, a start strobe during a codeword being ignored, and stray in_valid being ignored.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;

   localparam int GF_M         = 13;
   localparam logic [GF_M:0] GF_PRIM = 14'h201B;
   localparam int NUM_T        = 6;
   localparam int NUM_K        = 3;
   localparam int BYTE_W       = 8;
   localparam int MAX_PAR_BITS = 240;
   localparam int MAX_K_BYTES  = 516;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MSG  = 2'd1,
      ST_PAR  = 2'd2
   } enc_state_t;

   typedef logic [MAX_PAR_BITS-1:0] rem_t;

   // correction strength per selection index
   function automatic int t_of(int idx);
      case (idx)
         0:       return 7;
         1:       return 8;
         2:       return 14;
         3:       return 15;
         4:       return 17;
         default: return 18;
      endcase
   endfunction

   // parity length rounded up to whole bytes
   function automatic int par_bits_of(int idx);
      case (idx)
         0:       return 96;
         1:       return 104;
         2:       return 184;
         3:       return 200;
         4:       return 224;
         default: return 240;
      endcase
   endfunction

   function automatic int k_bytes_of(int idx);
      case (idx)
         0:       return 514;
         1:       return 515;
         default: return 516;
      endcase
   endfunction

   function automatic logic [GF_M-1:0] gf_mul(logic [GF_M-1:0] a, logic [GF_M-1:0] b);
      logic [GF_M-1:0] acc;
      logic [GF_M-1:0] x;
      acc = '0;
      x   = a;
      for (int i = 0; i < GF_M; i++) begin
         if (b[i]) acc = acc ^ x;
         if (x[GF_M-1]) x = {x[GF_M-2:0], 1'b0} ^ GF_PRIM[GF_M-1:0];
         else           x = {x[GF_M-2:0], 1'b0};
      end
      return acc;
   endfunction

   // binary minimal polynomial of alpha^e, built from its conjugate roots
   function automatic logic [GF_M:0] min_poly(int e);
      logic [GF_M:0][GF_M-1:0] c;
      logic [GF_M-1:0]         beta;
      logic [GF_M:0]           res;
      beta = GF_M'(1);
      for (int k = 0; k < e; k++) beta = gf_mul(beta, GF_M'(2));
      c = '0;
      c[0] = GF_M'(1);
      for (int j = 0; j < GF_M; j++) begin
         for (int k = GF_M; k >= 1; k--) c[k] = c[k-1] ^ gf_mul(beta, c[k]);
         c[0] = gf_mul(beta, c[0]);
         beta = gf_mul(beta, beta);
      end
      for (int k = 0; k <= GF_M; k++) res[k] = c[k][0];
      return res;
   endfunction

   // generator without its leading term, left-aligned in the remainder register
   function automatic rem_t gen_aligned(int idx);
      logic [MAX_PAR_BITS:0] g;
      logic [MAX_PAR_BITS:0] acc;
      logic [GF_M:0]         mp;
      int                    tt;
      int                    rb;
      tt = t_of(idx);
      rb = par_bits_of(idx);
      g  = '0;
      g[0] = 1'b1;
      for (int i = 1; i < 2*tt; i += 2) begin
         mp  = min_poly(i);
         acc = '0;
         for (int k = 0; k <= GF_M; k++)
            if (mp[k]) acc = acc ^ (g << k);
         g = acc;
      end
      g = g << (rb - GF_M*tt);
      g = g << (MAX_PAR_BITS - rb);
      return g[MAX_PAR_BITS-1:0];
   endfunction

endpackage

// File: rtl/bch_gen_table.sv
module bch_gen_table
   import bch_enc_pkg::*;
#(
   parameter int NUM_SEL = NUM_T,
   parameter int PAR_W   = MAX_PAR_BITS,
   parameter int IDX_W   = 3
) (
   input  logic [IDX_W-1:0] sel,
   output logic [PAR_W-1:0] gen
);

   logic [PAR_W-1:0] tbl [NUM_SEL];

   for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_row
      localparam logic [PAR_W-1:0] ROW = PAR_W'(gen_aligned(gi));
      assign tbl[gi] = ROW;
   end

   always_comb begin
      gen = tbl[NUM_SEL-1];
      for (int i = 0; i < NUM_SEL; i++)
         if (sel == IDX_W'(i)) gen = tbl[i];
   end

endmodule

// File: rtl/bch_lfsr_step.sv
module bch_lfsr_step #(
   parameter int PAR_W = 240,
   parameter int SYM_W = 8
) (
   input  logic [PAR_W-1:0] rem_in,
   input  logic [PAR_W-1:0] gen,
   input  logic [SYM_W-1:0] data_in,
   output logic [PAR_W-1:0] rem_out
);

   // SYM_W serial division steps, MSB of the symbol first, folded into one
   always_comb begin
      logic [PAR_W-1:0] r;
      logic             fb;
      r = rem_in;
      for (int b = SYM_W-1; b >= 0; b--) begin
         fb = data_in[b] ^ r[PAR_W-1];
         r  = {r[PAR_W-2:0], 1'b0} ^ ({PAR_W{fb}} & gen);
      end
      rem_out = r;
   end

endmodule

// File: rtl/bch_enc_ctrl.sv
module bch_enc_ctrl
   import bch_enc_pkg::*;
#(
   parameter int T_SEL_W  = 3,
   parameter int K_SEL_W  = 2,
   parameter int SYM_W    = 8,
   parameter int PAR_W    = MAX_PAR_BITS,
   parameter int MAX_K    = MAX_K_BYTES,
   parameter int NUM_TSEL = NUM_T,
   parameter int NUM_KSEL = NUM_K
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [T_SEL_W-1:0] t_sel,
   input  logic [K_SEL_W-1:0] k_sel,
   input  logic               in_valid,
   output logic               in_ready,
   output logic [T_SEL_W-1:0] t_idx,
   output logic               clear_rem,
   output logic               msg_take,
   output logic               par_shift,
   output logic               par_first,
   output logic               par_last
);

   localparam int KCNT_W = $clog2(MAX_K + 1);
   localparam int PCNT_W = $clog2(PAR_W / SYM_W + 1);
   localparam logic [T_SEL_W-1:0] T_TOP = T_SEL_W'(NUM_TSEL - 1);
   localparam logic [K_SEL_W-1:0] K_TOP = K_SEL_W'(NUM_KSEL - 1);

   enc_state_t          state_q;
   logic [T_SEL_W-1:0]  t_idx_c, t_idx_q;
   logic [K_SEL_W-1:0]  k_idx_c;
   logic [KCNT_W-1:0]   kcnt_q, k_len_q, k_len_c;
   logic [PCNT_W-1:0]   pcnt_q, r_len_q, r_len_c;

   always_comb begin
      t_idx_c = (t_sel > T_TOP) ? T_TOP : t_sel;
      k_idx_c = (k_sel > K_TOP) ? K_TOP : k_sel;
      k_len_c = KCNT_W'(k_bytes_of(int'(k_idx_c)));
      r_len_c = PCNT_W'(par_bits_of(int'(t_idx_c)) / SYM_W);
   end

   assign in_ready  = (state_q == ST_MSG);
   assign msg_take  = in_ready & in_valid;
   assign par_shift = (state_q == ST_PAR);
   assign par_first = par_shift & (pcnt_q == '0);
   assign par_last  = par_shift & (pcnt_q == r_len_q - 1'b1);
   assign clear_rem = (state_q == ST_IDLE) & start;
   assign t_idx     = t_idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         t_idx_q <= '0;
         k_len_q <= '0;
         r_len_q <= '0;
         kcnt_q  <= '0;
         pcnt_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  t_idx_q <= t_idx_c;
                  k_len_q <= k_len_c;
                  r_len_q <= r_len_c;
                  kcnt_q  <= '0;
                  state_q <= ST_MSG;
               end
            end
            ST_MSG: begin
               if (msg_take) begin
                  kcnt_q <= kcnt_q + 1'b1;
                  if (kcnt_q == k_len_q - 1'b1) begin
                     pcnt_q  <= '0;
                     state_q <= ST_PAR;
                  end
               end
            end
            ST_PAR: begin
               pcnt_q <= pcnt_q + 1'b1;
               if (par_last) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bch_byte_encoder.sv
module bch_byte_encoder
   import bch_enc_pkg::*;
#(
   parameter int SYM_W   = BYTE_W,
   parameter int PAR_W   = MAX_PAR_BITS,
   parameter int T_SEL_W = 3,
   parameter int K_SEL_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [T_SEL_W-1:0] t_sel,
   input  logic [K_SEL_W-1:0] k_sel,
   input  logic               in_valid,
   input  logic [SYM_W-1:0]   in_data,
   output logic               in_ready,
   output logic               out_valid,
   output logic [SYM_W-1:0]   out_data,
   output logic               out_parity_first,
   output logic               out_last
);

   if (PAR_W != MAX_PAR_BITS) begin : g_bad_par_w
      $error("PAR_W must match the generator table width");
   end
   if ((PAR_W % SYM_W) != 0) begin : g_bad_sym_w
      $error("parity width must be a whole number of symbols");
   end
   if ((1 << T_SEL_W) < NUM_T) begin : g_bad_tsel_w
      $error("t_sel too narrow for the strength table");
   end
   if ((1 << K_SEL_W) < NUM_K) begin : g_bad_ksel_w
      $error("k_sel too narrow for the length table");
   end

   logic [T_SEL_W-1:0] t_idx;
   logic               clear_rem, msg_take, par_shift, par_first, par_last;
   logic [PAR_W-1:0]   gen, rem_q, rem_next;

   bch_enc_ctrl #(
      .T_SEL_W (T_SEL_W),
      .K_SEL_W (K_SEL_W),
      .SYM_W   (SYM_W),
      .PAR_W   (PAR_W),
      .MAX_K   (MAX_K_BYTES),
      .NUM_TSEL(NUM_T),
      .NUM_KSEL(NUM_K)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .t_sel    (t_sel),
      .k_sel    (k_sel),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .t_idx    (t_idx),
      .clear_rem(clear_rem),
      .msg_take (msg_take),
      .par_shift(par_shift),
      .par_first(par_first),
      .par_last (par_last)
   );

   bch_gen_table #(
      .NUM_SEL(NUM_T),
      .PAR_W  (PAR_W),
      .IDX_W  (T_SEL_W)
   ) u_gen (
      .sel(t_idx),
      .gen(gen)
   );

   bch_lfsr_step #(
      .PAR_W(PAR_W),
      .SYM_W(SYM_W)
   ) u_step (
      .rem_in (rem_q),
      .gen    (gen),
      .data_in(in_data),
      .rem_out(rem_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q            <= '0;
         out_valid        <= 1'b0;
         out_data         <= '0;
         out_parity_first <= 1'b0;
         out_last         <= 1'b0;
      end else begin
         out_valid        <= msg_take | par_shift;
         out_parity_first <= par_first;
         out_last         <= par_last;
         if (msg_take)       out_data <= in_data;
         else if (par_shift) out_data <= rem_q[PAR_W-1 -: SYM_W];
         if (clear_rem)      rem_q <= '0;
         else if (msg_take)  rem_q <= rem_next;
         else if (par_shift) rem_q <= rem_q << SYM_W;
      end
   end

endmodule

// File: rtl/bch_byte_encoder_chk.sv
module bch_byte_encoder_chk #(
   parameter int SYM_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [SYM_W-1:0] in_data,
   input logic             out_valid,
   input logic [SYM_W-1:0] out_data,
   input logic             out_parity_first,
   input logic             out_last
);

   logic       in_par_q;
   logic [7:0] par_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_par_q  <= 1'b0;
         par_run_q <= '0;
      end else begin
         if (out_valid && out_last)              in_par_q <= 1'b0;
         else if (out_valid && out_parity_first) in_par_q <= 1'b1;
         if (out_valid && out_parity_first)      par_run_q <= 8'd1;
         else if (in_par_q && out_valid)         par_run_q <= par_run_q + 8'd1;
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !in_ready));

   assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)
                                  && !out_parity_first && !out_last));

   assert_parity_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (in_par_q && par_run_q >= 8'd11 && par_run_q <= 8'd29));

   assert_flags_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_parity_first || out_last) |-> out_valid);

   assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_parity_first, out_last}));

   assert_no_ready_in_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_par_q || out_parity_first) |-> !in_ready);

   assert_parity_gapless_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_par_q && !out_last) |-> out_valid);

endmodule

bind bch_byte_encoder bch_byte_encoder_chk #(.SYM_W(SYM_W)) u_chk (.*);

// File: tb/sim_bch_byte_encoder.sv
`timescale 1ns/1ps
module sim_bch_byte_encoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] t_sel = '0;
   logic [1:0] k_sel = '0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready, out_valid, out_parity_first, out_last;
   logic [7:0] out_data;

   int vectors = 0;
   int fails = 0;

   logic [7:0] msg [0:599];
   logic [7:0] ob  [0:699];

   always #10 clk = ~clk;

   bch_byte_encoder u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .t_sel(t_sel), .k_sel(k_sel),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data),
      .out_parity_first(out_parity_first), .out_last(out_last)
   );

   task automatic chk(bit ok, string req, string what, int act, int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_t(int ts);
      case (ts)
         0: return 7;  1: return 8;  2: return 14;
         3: return 15; 4: return 17; default: return 18;
      endcase
   endfunction

   function automatic int exp_k(int ks);
      case (ks)
         0: return 514; 1: return 515; default: return 516;
      endcase
   endfunction

   function automatic int exp_r(int tt);
      case (tt)
         7: return 12;  8: return 13;  14: return 23;
         15: return 25; 17: return 28; default: return 30;
      endcase
   endfunction

   // GF(2^13), x^13 = x^4 + x^3 + x + 1
   function automatic logic [12:0] fmul(logic [12:0] a, logic [12:0] b);
      logic [12:0] p;
      logic [12:0] x;
      p = '0;
      x = a;
      for (int i = 0; i < 13; i++) begin
         if (b[i]) p = p ^ x;
         x = x[12] ? ({x[11:0], 1'b0} ^ 13'h001B) : {x[11:0], 1'b0};
      end
      return p;
   endfunction

   // returns first root index i with nonzero c(alpha^i), or 0
   function automatic int first_bad_root(int nbytes, int tt);
      logic [12:0] ai;
      logic [12:0] s;
      ai = 13'd1;
      for (int i = 1; i <= 2*tt; i++) begin
         ai = fmul(ai, 13'd2);
         s  = '0;
         for (int n = 0; n < nbytes; n++)
            for (int b = 7; b >= 0; b--)
               s = fmul(s, ai) ^ {12'd0, ob[n][b]};
         if (s != 13'd0) return i;
      end
      return 0;
   endfunction

   task automatic run_word(int ts, int ks, int mode, bit gaps, bit junk, bit restart);
      int tt, kk, rr, pad, sent, got, cyc, first_idx, last_idx, first_cyc, last_cyc;
      int mism, nz, bad;
      bit done, rdy_bad, dup, idle_bad;
      tt = exp_t(ts); kk = exp_k(ks); rr = exp_r(tt); pad = 8*rr - 13*tt;
      for (int i = 0; i < kk; i++) begin
         case (mode)
            0:       msg[i] = 8'h00;
            1:       msg[i] = 8'($urandom);
            2:       msg[i] = 8'hFF;
            default: msg[i] = (i == 0) ? 8'h80 : 8'h00;
         endcase
      end
      idle_bad = 1'b0;
      if (junk) begin
         for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1; in_data = 8'h5A;
            @(negedge clk);
            if (out_valid) idle_bad = 1'b1;
         end
         chk(!idle_bad, "R8", "idle in_valid produced output", int'(idle_bad), 0);
      end
      in_valid = 1'b0; t_sel = 3'(ts); k_sel = 2'(ks); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      sent = 0; got = 0; cyc = 0; done = 0; rdy_bad = 0; dup = 0;
      first_idx = -1; last_idx = -1; first_cyc = 0; last_cyc = 0;
      while (!done && cyc < 3000) begin
         if (out_valid && got < 700) begin
            ob[got] = out_data;
            if (out_parity_first) begin
               if (first_idx >= 0) dup = 1'b1;
               else begin first_idx = got; first_cyc = cyc; end
            end
            if (out_last) begin last_idx = got; last_cyc = cyc; done = 1'b1; end
            got++;
         end
         if (first_idx >= 0 && in_ready) rdy_bad = 1'b1;
         if (restart && sent == 100) begin
            start = 1'b1; t_sel = 3'((ts + 2) % 6); k_sel = 2'((ks + 1) % 3);
         end else start = 1'b0;
         if (in_ready && sent < kk && (!gaps || $urandom_range(3) != 0)) begin
            in_valid = 1'b1; in_data = msg[sent]; sent++;
         end else if (!in_ready) begin
            in_valid = junk; in_data = 8'hC3;
         end else begin
            in_valid = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      in_valid = 1'b0; start = 1'b0;

      chk(got == kk + rr, "R4", "codeword length", got, kk + rr);
      mism = 0;
      for (int i = 0; i < kk; i++) if (ob[i] != msg[i]) mism++;
      chk(mism == 0, "R3", "message byte mismatches", mism, 0);
      chk(first_idx == kk, "R6", "first-parity flag position", first_idx, kk);
      chk(!dup, "R6", "duplicate first-parity flag", int'(dup), 0);
      chk(last_idx == kk + rr - 1, "R6", "last flag position", last_idx, kk + rr - 1);
      chk(!rdy_bad, "R7", "in_ready during parity", int'(rdy_bad), 0);
      chk(last_cyc - first_cyc == rr - 1, "R7", "parity span cycles", last_cyc - first_cyc, rr - 1);
      bad = (got == kk + rr) ? first_bad_root(got, tt) : -1;
      chk(bad == 0, "R5", "nonzero root evaluation index", bad, 0);
      chk((int'(ob[kk + rr - 1]) & ((1 << pad) - 1)) == 0, "R5", "padding bits",
          int'(ob[kk + rr - 1]) & ((1 << pad) - 1), 0);
      if (mode == 0) begin
         nz = 0;
         for (int i = kk; i < kk + rr; i++) if (ob[i] != 8'h00) nz++;
         chk(nz == 0, "R5", "zero message nonzero parity bytes", nz, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!in_ready && !out_valid && !out_last && !out_parity_first, "R1", "outputs in reset",
          int'({in_ready, out_valid, out_last, out_parity_first}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!in_ready && !out_valid && !out_last && !out_parity_first, "R1", "outputs idle after reset",
          int'({in_ready, out_valid, out_last, out_parity_first}), 0);
      // R2 sweep over every strength and length
      for (int ts = 0; ts < 6; ts++)
         for (int ks = 0; ks < 3; ks++)
            run_word(ts, ks, 1, ((ts + ks) % 2) == 1, ks == 1, 1'b0);
      run_word(2, 0, 0, 1'b0, 1'b0, 1'b0);  // R5 zero message
      run_word(5, 2, 2, 1'b1, 1'b1, 1'b0);  // all ones, R8 stray valid
      run_word(0, 1, 3, 1'b0, 1'b0, 1'b0);  // single high-order bit
      run_word(1, 0, 1, 1'b1, 1'b0, 1'b1);  // R2 start while busy ignored
      run_word(6, 3, 1, 1'b0, 1'b1, 1'b0);  // R2 clamped codes
      run_word(7, 3, 1, 1'b1, 1'b0, 1'b0);  // R2 clamped codes
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule